// File: doc/BRIEF.md
# NAND flash bus interface controller

This block connects a simple register-access host port to a raw 8-bit NAND flash bus. Software sets the command-latch, address-latch, chip-enable and chip-select lines directly through a mode register. It then reads or writes a data register. Each data-register access becomes exactly one read strobe or one write strobe on the flash bus. Strobe length and data hold time come from two 4-bit fields in a timing register.

A data access holds the host port until its flash cycle is complete, so back-to-back accesses are spaced by the programmed timing. The host sees the flash ready/busy pin in a status register. A reset register returns the mode and timing state to its power-up values; its request bit reads back as set until that reset completes.

Registers are addressed by word index, which is the byte offset divided by four:

| Index | Register |
|---|---|
| 0 | data |
| 1 | mode |
| 2 | status |
| 3 | interrupt status |
| 4 | interrupt mask |
| 5 | timing |
| 6 | reset |

Top module: `nand_bus_ctrl`

## Requirements
- R1: Mode register (index 1) bit 0 drives `fl_cle`, bit 1 drives `fl_ale`, and bit 4 set drives `fl_ce_n` low. Bit 7 is the data-write enable. Reading the mode register returns the written value masked with 0x9F.
- R2: Mode bits 3:2 hold a chip-select number n. `fl_cs_n[n]` is low and every other `fl_cs_n` line is high.
- R3: A data write (index 0) with mode bit 7 set drives `host_wdata` onto `fl_dq_out`. It holds `fl_we_n` low for W+1 clocks, starting in the cycle after the request is first presented, where W is timing bits 3:0. `fl_dq_out` stays stable during the strobe. `fl_we_n` and `fl_re_n` are never low together.
- R4: `fl_dq_oe` is high only from the first write-strobe cycle to the last hold cycle of a write. The hold lasts H+2 clocks when `HOLD_ADD`=1 and H clocks when `HOLD_ADD`=0, where H is timing bits 7:4. It is never high during a read.
- R5: A data read (index 0, `host_wr`=0) holds `fl_re_n` low for W+1 clocks. It then applies the same hold time, and returns the `fl_dq_in` byte sampled in the last strobe cycle on `host_rdata` when `host_ready` rises.
- R6: During a data access `host_ready` stays low until the sequence ends. The access completes 1+(W+1)+hold cycles after it is presented. The host must keep the request steady until `host_ready` is high.
- R7: A data write while mode bit 7 is clear is ignored. It completes in the cycle it is presented, with no strobe and no output enable.
- R8: Timing register (index 5) holds H in bits 7:4 and W in bits 3:0, and reads back as written. Its reset value is {`DEF_HOLD`,`DEF_WIDTH`}.
- R9: Status register (index 2) bit 7 reads 1 while `fl_rb_n` is low, and 0 otherwise.
- R10: Writing 1 to bit 0 of the reset register (index 6) resets the controller. That bit then reads 1 for `RST_CYCLES` cycles and 0 afterwards. The mode register is cleared and the timing register returns to its reset value.
- R11: Indices 3, 4 and 7 read zero, and writes to them change no register.
- R12: After `rst_n` is released, the controller starts idle. CLE and ALE are low, the chip is deselected (`fl_ce_n` high), chip-select 0 is asserted, both strobes are high and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until `host_ready` |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register word index |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid with `host_ready` |
| host_ready | output | 1 | Access completes in this cycle |
| fl_cle | output | 1 | Flash command latch enable |
| fl_ale | output | 1 | Flash address latch enable |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_cs_n | output | NUM_CS | One-hot active-low chip selects |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_re_n | output | 1 | Flash read strobe, active low |
| fl_dq_out | output | 8 | Flash data bus, driven value |
| fl_dq_oe | output | 1 | Flash data bus output enable |
| fl_dq_in | input | 8 | Flash data bus, sampled value |
| fl_rb_n | input | 1 | Flash ready/busy, low = busy |

## Verification
The bench builds the controller with four chip selects, `HOLD_ADD`=1, a four-cycle soft reset and a default timing of hold 3, width 5. With 4-bit fields this small, every width and hold pair from 1 to 15 is swept for both a write and a read. Strobe length, hold length, total latency and returned byte are computed from the field values for each pair. All 256 mode values are also applied, which covers every chip-select number and latch-line combination.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

  localparam int REG_IDX_W = 3;

  localparam logic [REG_IDX_W-1:0] RI_DATA    = 3'd0;
  localparam logic [REG_IDX_W-1:0] RI_MODE    = 3'd1;
  localparam logic [REG_IDX_W-1:0] RI_STAT    = 3'd2;
  localparam logic [REG_IDX_W-1:0] RI_TIMING  = 3'd5;
  localparam logic [REG_IDX_W-1:0] RI_RESET   = 3'd6;

  // mode register bit positions
  localparam int MB_CLE = 0;
  localparam int MB_ALE = 1;
  localparam int MB_CSL = 2;
  localparam int MB_CSH = 3;
  localparam int MB_CE  = 4;
  localparam int MB_WE  = 7;

  localparam logic [7:0] MODE_MASK = 8'h9F;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_STRB = 2'd1,
    SQ_HOLD = 2'd2,
    SQ_DONE = 2'd3
  } seq_state_e;

  // strobe lasts one clock longer than the field value
  function automatic logic [4:0] strobe_cycles(input logic [3:0] w);
    return {1'b0, w} + 5'd1;
  endfunction

  // hold length, optionally extended by two clocks
  function automatic logic [4:0] hold_cycles(input logic [3:0] h, input bit add);
    return add ? ({1'b0, h} + 5'd2) : {1'b0, h};
  endfunction

endpackage

// File: rtl/nbc_regs.sv
module nbc_regs #(
  parameter int RST_CYCLES = 4,
  parameter int DEF_HOLD   = 3,
  parameter int DEF_WIDTH  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_mode,
  input  logic       wr_timing,
  input  logic       wr_reset,
  input  logic [7:0] wdata,
  output logic [7:0] mode_q,
  output logic [7:0] timing_q,
  output logic       rst_busy
);
  import nbc_pkg::*;

  localparam int         RC_W        = $clog2(RST_CYCLES + 1);
  localparam logic [7:0] TIMING_INIT = {4'(DEF_HOLD), 4'(DEF_WIDTH)};

  logic [RC_W-1:0] rst_cnt;

  assign rst_busy = (rst_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      timing_q <= TIMING_INIT;
      rst_cnt  <= '0;
    end else if (rst_busy) begin
      mode_q   <= '0;
      timing_q <= TIMING_INIT;
      rst_cnt  <= rst_cnt - RC_W'(1);
    end else begin
      if (wr_reset)  rst_cnt  <= RC_W'(RST_CYCLES);
      if (wr_mode)   mode_q   <= wdata & MODE_MASK;
      if (wr_timing) timing_q <= wdata;
    end
  end

endmodule

// File: rtl/nbc_strobe_seq.sv
module nbc_strobe_seq #(
  parameter bit HOLD_ADD = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       start,
  input  logic       is_read,
  input  logic [7:0] wbyte,
  input  logic [3:0] tim_width,
  input  logic [3:0] tim_hold,
  input  logic [7:0] dq_in,
  output logic       we_n,
  output logic       re_n,
  output logic       oe,
  output logic [7:0] dq_out,
  output logic [7:0] rbyte,
  output logic       busy,
  output logic       done,
  output logic       strobe_last
);
  import nbc_pkg::*;

  seq_state_e state;
  logic [4:0] cnt;
  logic       rd_q;
  logic [4:0] hold_len;

  assign hold_len    = hold_cycles(tim_hold, HOLD_ADD);
  assign strobe_last = (state == SQ_STRB) && (cnt == 5'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      cnt    <= '0;
      rd_q   <= 1'b0;
      dq_out <= '0;
      rbyte  <= '0;
    end else if (clr) begin
      state  <= SQ_IDLE;
      cnt    <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) begin
          state <= SQ_STRB;
          cnt   <= strobe_cycles(tim_width) - 5'd1;
          rd_q  <= is_read;
          if (!is_read) dq_out <= wbyte;
        end
        SQ_STRB: if (strobe_last) begin
          if (rd_q) rbyte <= dq_in;
          if (hold_len == 5'd0) begin
            state <= SQ_DONE;
          end else begin
            state <= SQ_HOLD;
            cnt   <= hold_len - 5'd1;
          end
        end else begin
          cnt <= cnt - 5'd1;
        end
        SQ_HOLD: if (cnt == 5'd0) state <= SQ_DONE;
                 else cnt <= cnt - 5'd1;
        SQ_DONE: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign we_n = !((state == SQ_STRB) && !rd_q);
  assign re_n = !((state == SQ_STRB) && rd_q);
  assign oe   = !rd_q && ((state == SQ_STRB) || (state == SQ_HOLD));
  assign busy = (state == SQ_STRB) || (state == SQ_HOLD);
  assign done = (state == SQ_DONE);

endmodule

// File: rtl/nbc_cs_decode.sv
module nbc_cs_decode #(
  parameter int NUM_CS = 4
) (
  input  logic [1:0]        sel,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = (sel != 2'(i));
  end
endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl #(
  parameter int NUM_CS     = 4,
  parameter bit HOLD_ADD   = 1'b1,
  parameter int RST_CYCLES = 4,
  parameter int DEF_HOLD   = 3,
  parameter int DEF_WIDTH  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [2:0]        host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_ready,
  output logic              fl_cle,
  output logic              fl_ale,
  output logic              fl_ce_n,
  output logic [NUM_CS-1:0] fl_cs_n,
  output logic              fl_we_n,
  output logic              fl_re_n,
  output logic [7:0]        fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_in,
  input  logic              fl_rb_n
);
  import nbc_pkg::*;

  logic [7:0] mode_q, timing_q, rbyte;
  logic       rst_busy, seq_busy, seq_done, seq_start, strobe_last;
  logic       hit_data, hit_mode, hit_timing, hit_reset, mode_we;
  logic       data_ignored;

  assign hit_data   = host_req && (host_addr == RI_DATA);
  assign hit_mode   = host_req && (host_addr == RI_MODE);
  assign hit_timing = host_req && (host_addr == RI_TIMING);
  assign hit_reset  = host_req && (host_addr == RI_RESET);
  assign mode_we    = mode_q[MB_WE];

  assign data_ignored = host_wr && !mode_we;
  assign seq_start    = hit_data && !data_ignored && !rst_busy && !seq_busy && !seq_done;

  nbc_regs #(
    .RST_CYCLES(RST_CYCLES),
    .DEF_HOLD  (DEF_HOLD),
    .DEF_WIDTH (DEF_WIDTH)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_mode  (hit_mode && host_wr),
    .wr_timing(hit_timing && host_wr),
    .wr_reset (hit_reset && host_wr && host_wdata[0]),
    .wdata    (host_wdata),
    .mode_q   (mode_q),
    .timing_q (timing_q),
    .rst_busy (rst_busy)
  );

  nbc_strobe_seq #(.HOLD_ADD(HOLD_ADD)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (rst_busy),
    .start      (seq_start),
    .is_read    (!host_wr),
    .wbyte      (host_wdata),
    .tim_width  (timing_q[3:0]),
    .tim_hold   (timing_q[7:4]),
    .dq_in      (fl_dq_in),
    .we_n       (fl_we_n),
    .re_n       (fl_re_n),
    .oe         (fl_dq_oe),
    .dq_out     (fl_dq_out),
    .rbyte      (rbyte),
    .busy       (seq_busy),
    .done       (seq_done),
    .strobe_last(strobe_last)
  );

  nbc_cs_decode #(.NUM_CS(NUM_CS)) u_cs (
    .sel (mode_q[MB_CSH:MB_CSL]),
    .cs_n(fl_cs_n)
  );

  assign fl_cle  = mode_q[MB_CLE];
  assign fl_ale  = mode_q[MB_ALE];
  assign fl_ce_n = !mode_q[MB_CE];

  always_comb begin
    host_ready = 1'b1;
    if (host_addr == RI_DATA) host_ready = data_ignored || seq_done;
  end

  always_comb begin
    unique case (host_addr)
      RI_DATA:   host_rdata = rbyte;
      RI_MODE:   host_rdata = mode_q;
      RI_STAT:   host_rdata = {!fl_rb_n, 7'b0};
      RI_TIMING: host_rdata = timing_q;
      RI_RESET:  host_rdata = {7'b0, rst_busy};
      default:   host_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/nbc_chk.sv
module nbc_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fl_we_n,
  input logic              fl_re_n,
  input logic              fl_dq_oe,
  input logic [7:0]        fl_dq_out,
  input logic [NUM_CS-1:0] fl_cs_n,
  input logic              fl_cle,
  input logic              fl_ale,
  input logic              fl_ce_n,
  input logic              host_ready,
  input logic              seq_busy,
  input logic              rst_busy
);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_re_n));

  // R3
  dq_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> $stable(fl_dq_out));

  // R4
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_dq_oe |-> fl_re_n);

  // R4
  oe_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_dq_oe) |-> fl_we_n);

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~fl_cs_n) == 1);

  // R6
  ready_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> !host_ready);

  // R10
  soft_rst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |=> (fl_ce_n && !fl_cle && !fl_ale));

endmodule

bind nand_bus_ctrl nbc_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fl_we_n   (fl_we_n),
  .fl_re_n   (fl_re_n),
  .fl_dq_oe  (fl_dq_oe),
  .fl_dq_out (fl_dq_out),
  .fl_cs_n   (fl_cs_n),
  .fl_cle    (fl_cle),
  .fl_ale    (fl_ale),
  .fl_ce_n   (fl_ce_n),
  .host_ready(host_ready),
  .seq_busy  (seq_busy),
  .rst_busy  (rst_busy)
);

// File: tb/sim_nand_bus_ctrl.sv
module sim_nand_bus_ctrl;

  localparam int NCS = 4;
  localparam int RSTC = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           host_req = 1'b0, host_wr = 1'b0;
  logic [2:0]     host_addr = '0;
  logic [7:0]     host_wdata = '0;
  logic [7:0]     host_rdata;
  logic           host_ready;
  logic           fl_cle, fl_ale, fl_ce_n, fl_we_n, fl_re_n, fl_dq_oe;
  logic [NCS-1:0] fl_cs_n;
  logic [7:0]     fl_dq_out;
  logic [7:0]     fl_dq_in = '0;
  logic           fl_rb_n = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nand_bus_ctrl #(
    .NUM_CS(NCS), .HOLD_ADD(1'b1), .RST_CYCLES(RSTC), .DEF_HOLD(3), .DEF_WIDTH(5)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_ce_n(fl_ce_n),
    .fl_cs_n(fl_cs_n), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_rb_n(fl_rb_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] idx, input logic [7:0] val);
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b1; host_addr = idx; host_wdata = val;
    @(negedge clk);
    host_req = 1'b0; host_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] idx, output logic [7:0] val);
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b0; host_addr = idx;
    #1 val = host_rdata;
    host_req = 1'b0;
  endtask

  task automatic data_xfer(input bit is_wr, input logic [7:0] b,
                           output int strb, output int hold, output int oe_strb,
                           output int waitc, output int baddq, output logic [7:0] rd);
    strb = 0; hold = 0; oe_strb = 0; waitc = 0; baddq = 0;
    @(negedge clk);
    host_req = 1'b1; host_wr = is_wr; host_addr = 3'd0; host_wdata = b;
    for (int k = 0; k < 100; k++) begin
      #1;
      if (host_ready) break;
      waitc++;
      if (!fl_we_n || !fl_re_n) strb++;
      if (!fl_we_n && fl_dq_out != b) baddq++;
      if (fl_dq_oe && fl_we_n) hold++;
      if (fl_dq_oe && !fl_we_n) oe_strb++;
      @(negedge clk);
    end
    rd = host_rdata;
    @(negedge clk);
    host_req = 1'b0; host_wr = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    int s, h, os, wc, bd, ones;
    logic [7:0] rb;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    chk("R12 cle", fl_cle, 0);
    chk("R12 ale", fl_ale, 0);
    chk("R12 ce_n", fl_ce_n, 1);
    chk("R12 cs_n", fl_cs_n, 4'b1110);
    chk("R12 we_n", fl_we_n, 1);
    chk("R12 re_n", fl_re_n, 1);
    chk("R12 oe", fl_dq_oe, 0);
    reg_read(3'd5, rv); chk("R8 timing reset value", rv, 8'h35);
    reg_read(3'd1, rv); chk("R12 mode reset value", rv, 0);

    // R1 / R2 mode sweep
    for (int v = 0; v < 256; v++) begin
      reg_write(3'd1, 8'(v));
      #1;
      chk("R1 cle", fl_cle, v & 1);
      chk("R1 ale", fl_ale, (v >> 1) & 1);
      chk("R1 ce_n", fl_ce_n, ((v >> 4) & 1) ^ 1);
      chk("R2 cs_n", fl_cs_n, (~(1 << ((v >> 2) & 3))) & 4'hF);
      reg_read(3'd1, rv);
      chk("R1 readback", rv, v & 8'h9F);
    end

    // R9 status
    fl_rb_n = 1'b0;
    reg_read(3'd2, rv); chk("R9 busy", rv, 8'h80);
    fl_rb_n = 1'b1;
    reg_read(3'd2, rv); chk("R9 ready", rv, 8'h00);

    // R7 ignored data write
    reg_write(3'd1, 8'h10);
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b1; host_addr = 3'd0; host_wdata = 8'hA5;
    #1 chk("R7 immediate ready", host_ready, 1);
    @(negedge clk);
    host_req = 1'b0; host_wr = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R7 no strobe", fl_we_n, 1);
      chk("R7 no oe", fl_dq_oe, 0);
      @(negedge clk);
    end

    // R3..R6, R8 sweep
    reg_write(3'd1, 8'h90);
    for (int w = 1; w < 16; w++) begin
      for (int hh = 1; hh < 16; hh++) begin
        logic [7:0] wb, ib;
        wb = 8'((w * 16 + hh) ^ 8'hC3);
        ib = 8'((w * 16 + hh) ^ 8'h5A);
        reg_write(3'd5, 8'(hh * 16 + w));
        reg_read(3'd5, rv);
        chk("R8 timing readback", rv, hh * 16 + w);
        data_xfer(1'b1, wb, s, h, os, wc, bd, rb);
        chk("R3 write strobe length", s, w + 1);
        chk("R3 data on bus", bd, 0);
        chk("R4 hold length", h, hh + 2);
        chk("R4 oe during strobe", os, w + 1);
        chk("R6 write latency", wc, 1 + (w + 1) + (hh + 2));
        fl_dq_in = ib;
        data_xfer(1'b0, 8'h00, s, h, os, wc, bd, rb);
        chk("R5 read strobe length", s, w + 1);
        chk("R5 read byte", rb, ib);
        chk("R4 no oe on read", h + os, 0);
        chk("R6 read latency", wc, 1 + (w + 1) + (hh + 2));
      end
    end

    // R11 unmapped registers
    reg_write(3'd1, 8'h83);
    reg_write(3'd3, 8'hFF);
    reg_write(3'd4, 8'hFF);
    reg_write(3'd7, 8'hFF);
    reg_read(3'd3, rv); chk("R11 index 3 reads zero", rv, 0);
    reg_read(3'd4, rv); chk("R11 index 4 reads zero", rv, 0);
    reg_read(3'd7, rv); chk("R11 index 7 reads zero", rv, 0);
    reg_read(3'd1, rv); chk("R11 mode untouched", rv, 8'h83);

    // R10 soft reset
    reg_write(3'd1, 8'h9B);
    reg_write(3'd5, 8'h77);
    reg_write(3'd6, 8'h01);
    ones = 0;
    host_req = 1'b1; host_wr = 1'b0; host_addr = 3'd6;
    for (int k = 0; k < RSTC + 2; k++) begin
      #1;
      if (host_rdata[0]) ones++;
      @(negedge clk);
    end
    host_req = 1'b0;
    chk("R10 reset bit duration", ones, RSTC);
    #1;
    chk("R10 ce_n released", fl_ce_n, 1);
    chk("R10 cle cleared", fl_cle, 0);
    reg_read(3'd1, rv); chk("R10 mode cleared", rv, 0);
    reg_read(3'd5, rv); chk("R10 timing restored", rv, 8'h35);
    reg_read(3'd6, rv); chk("R10 reset bit clear", rv, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule